// File: doc/BRIEF.md
# Multi-mode endian load/store unit

This block sits between a processor load/store path and a 32-bit data memory whose byte lanes are numbered from the lowest address upward. Each request carries an address, an access size, a write flag, write data and a byte-order mode. For that request the unit produces the word address, the byte enables and the write lanes for the memory. It then turns the memory's read word back into a register value.

Five byte orders are supported. Plain little-endian is the first. Big-endian comes in two forms: one reverses the bytes of halfwords and words, and the other keeps the data lanes as they are but redirects sub-word accesses to the opposite end of the word. The last two are mixed layouts that split a word into 16-bit halves. Requests that are not naturally aligned are flagged and never reach the memory.

The memory is taken to return read data on the cycle after a read request. The unit registers the converted result one cycle later, so a load result appears two cycles after its request. The mode is captured with the request, so later changes on the mode input do not affect a load that is already in flight.

Top module: `endian_lsu`

## Requirements
- R1: Lane n is mem_wdata_o[8n+7:8n], mem_rdata_i[8n+7:8n] and mem_be_o[n], and lane n sits at word address plus n. Mode 0 is little-endian: byte k of a value goes to lane offset+k. Mode codes 5 to 7 behave as mode 0. Size codes are 0 byte, 1 halfword, 2 word, and 3 behaves as a word. mem_addr_o is the request address with bits [1:0] cleared. Bits inside a byte are never reordered.
- R2: Mode 1 is byte-invariant big-endian. Byte accesses behave as in mode 0. Halfword and word accesses have their bytes reversed, so word 0x0A0B0C0D is held in lanes 0..3 as 0A,0B,0C,0D.
- R3: Mode 2 is word-invariant big-endian. Word accesses behave as in mode 0. A byte access uses lane offset XOR 3, and a halfword access uses lanes starting at offset XOR 2. No byte swap is applied.
- R4: Mode 3 is a mixed layout with the more significant half first and each half little-endian: word 0x0A0B0C0D is held in lanes 0..3 as 0B,0A,0D,0C. Halfword accesses behave as in mode 0.
- R5: Mode 4 is a mixed layout with the less significant half first and each half big-endian: word 0x0A0B0C0D is held in lanes 0..3 as 0C,0D,0A,0B. Halfword accesses are byte-swapped.
- R6: In every mode, a halfword at an odd address or a word at an address that is not a multiple of 4 raises misalign_o while req_i is high. That request then drives mem_req_o low and mem_be_o to zero, and memory is left unchanged.
- R7: An accepted request asserts exactly the byte enables of the lanes it touches: 1 for a byte, 2 for a halfword, 4 for a word. Write lanes that are not touched are driven to zero.
- R8: Load results are zero-extended into rdata_o, and rvalid_o pulses for one cycle. Both appear two clock edges after the request edge. Stores and rejected requests produce no rvalid_o.
- R9: The mode is sampled with the request. Changing mode_i after the request edge does not alter that load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| mode_i | input | 3 | Byte-order mode code |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Store value, right-aligned |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_be_o | output | 4 | Memory byte-lane enables |
| mem_wdata_o | output | 32 | Memory write lanes |
| mem_rdata_i | input | 32 | Memory read lanes, one cycle after request |
| misalign_o | output | 1 | Current request is misaligned |
| rdata_o | output | 32 | Load result aligned to the register |
| rvalid_o | output | 1 | Load result valid |

## Verification
On every cycle, the assertions check the following: rejected requests stay off the memory, the byte-enable count matches the size, and the word address is aligned. They also check that word-invariant mode passes word data through unchanged and redirects byte enables, and that rvalid_o follows accepted loads by exactly two edges. The actual lane placement of each byte order, the zero extension, and the independence of an in-flight load from later mode changes can only be shown by the bench. It does this by storing and loading known patterns through a memory model and comparing the bytes against values derived from the lane tables.

// File: rtl/endian_pkg.sv
package endian_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  localparam logic [2:0] MODE_LE      = 3'd0;
  localparam logic [2:0] MODE_BE_BYTE = 3'd1;
  localparam logic [2:0] MODE_BE_WORD = 3'd2;
  localparam logic [2:0] MODE_MIX_HI  = 3'd3;
  localparam logic [2:0] MODE_MIX_LO  = 3'd4;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;

  typedef struct packed {
    logic [OFF_W-1:0] sub_xor;   // address rewrite for sub-word accesses
    logic [OFF_W-1:0] word_mask; // lane = byte index ^ word_mask
    logic             half_swap; // swap bytes within a halfword
  } ord_t;

  function automatic ord_t ord_decode(input logic [2:0] mode, input logic [1:0] size);
    ord_t o;
    o = '0;
    case (mode)
      MODE_BE_BYTE: begin
        o.word_mask = 2'd3;
        o.half_swap = 1'b1;
      end
      MODE_BE_WORD: begin
        if (size == SZ_B)      o.sub_xor = 2'd3;
        else if (size == SZ_H) o.sub_xor = 2'd2;
      end
      MODE_MIX_HI: o.word_mask = 2'd2;
      MODE_MIX_LO: begin
        o.word_mask = 2'd1;
        o.half_swap = 1'b1;
      end
      default: ;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/endian_req_map.sv
module endian_req_map
  import endian_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          size_i,
  input  logic [2:0]          mode_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [LANES-1:0]    mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                misalign_o,
  output logic                ld_go_o,
  output logic [OFF_W-1:0]    eff_off_o,
  output ord_t                ord_o
);
  ord_t             ord;
  logic [OFF_W-1:0] eo;
  logic             is_word, is_half, is_byte, bad, go;

  assign ord     = ord_decode(mode_i, size_i);
  assign is_word = size_i[1];
  assign is_half = (size_i == SZ_H);
  assign is_byte = (size_i == SZ_B);
  assign bad     = (is_half & addr_i[0]) | (is_word & (|addr_i[OFF_W-1:0]));
  assign go      = req_i & ~bad;
  assign eo      = addr_i[OFF_W-1:0] ^ ord.sub_xor;

  assign misalign_o = req_i & bad;
  assign mem_req_o  = go;
  assign mem_we_o   = go & we_i;
  assign mem_addr_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign ld_go_o    = go & ~we_i;
  assign eff_off_o  = eo;
  assign ord_o      = ord;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W-1:0] src;
    logic             hit;
    always_comb begin
      src = '0;
      hit = 1'b0;
      if (is_word) begin
        src = OFF_W'(i) ^ ord.word_mask;
        hit = 1'b1;
      end else if (is_half) begin
        src = {{(OFF_W-1){1'b0}}, 1'(i) ^ ord.half_swap};
        hit = (OFF_W'(i) >> 1) == (eo >> 1);
      end else if (is_byte) begin
        hit = (OFF_W'(i) == eo);
      end
    end
    assign mem_be_o[i]          = go & hit;
    assign mem_wdata_o[8*i +: 8] = (go & we_i & hit) ? wdata_i[8*src +: 8] : 8'h00;
  end
endmodule

// File: rtl/endian_rd_align.sv
module endian_rd_align
  import endian_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_go_i,
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  eff_off_i,
  input  ord_t              ord_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic             pend_q;
  logic [1:0]       size_q;
  logic [OFF_W-1:0] off_q;
  ord_t             ord_q;
  logic [DATA_W-1:0] aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      size_q <= '0;
      off_q  <= '0;
      ord_q  <= '0;
    end else begin
      pend_q <= ld_go_i;
      if (ld_go_i) begin
        size_q <= size_i;
        off_q  <= eff_off_i;
        ord_q  <= ord_i;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [OFF_W-1:0] lane;
    logic             keep;
    always_comb begin
      lane = '0;
      keep = 1'b0;
      if (size_q[1]) begin
        lane = OFF_W'(k) ^ ord_q.word_mask;
        keep = 1'b1;
      end else if (size_q == SZ_H) begin
        lane = {off_q[OFF_W-1:1], 1'(k) ^ ord_q.half_swap};
        keep = (k < 2);
      end else begin
        lane = off_q;
        keep = (k == 0);
      end
    end
    assign aligned[8*k +: 8] = keep ? mem_rdata_i[8*lane +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= pend_q;
      if (pend_q) rdata_o <= aligned;
    end
  end
endmodule

// File: rtl/endian_lsu.sv
module endian_lsu
  import endian_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              misalign_o,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  logic             ld_go;
  logic [OFF_W-1:0] eff_off;
  ord_t             ord;

  endian_req_map #(.ADDR_W(ADDR_W)) u_map (
    .req_i       (req_i),
    .we_i        (we_i),
    .size_i      (size_i),
    .mode_i      (mode_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .misalign_o  (misalign_o),
    .ld_go_o     (ld_go),
    .eff_off_o   (eff_off),
    .ord_o       (ord)
  );

  endian_rd_align u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_go_i     (ld_go),
    .size_i      (size_i),
    .eff_off_i   (eff_off),
    .ord_i       (ord),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );
endmodule

// File: rtl/endian_lsu_chk.sv
module endian_lsu_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic [31:0]       mem_wdata_o,
  input logic              misalign_o,
  input logic              rvalid_o
);
  logic ld_q1, ld_q2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q1 <= 1'b0;
      ld_q2 <= 1'b0;
    end else begin
      ld_q1 <= mem_req_o & ~mem_we_o;
      ld_q2 <= ld_q1;
    end
  end

  a_r6_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && mem_be_o == 4'b0000));

  a_r6_odd_half_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd1 && addr_i[0]) |-> misalign_o);

  a_r7_be_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == ((size_i == 2'd0) ? 1 : (size_i == 2'd1) ? 2 : 4)));

  a_r1_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o == {addr_i[ADDR_W-1:2], 2'b00}));

  a_r3_word_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mode_i == 3'd2 && size_i[1]) |-> (mem_wdata_o == wdata_i));

  a_r3_byte_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mode_i == 3'd2 && size_i == 2'd0) |-> (mem_be_o == (4'b0001 << (addr_i[1:0] ^ 2'd3))));

  a_r8_rvalid_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o == ld_q2);
endmodule

bind endian_lsu endian_lsu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .size_i      (size_i),
  .mode_i      (mode_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .misalign_o  (misalign_o),
  .rvalid_o    (rvalid_o)
);

// File: tb/tb_endian_lsu.sv
`timescale 1ns/1ps
module tb_endian_lsu;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [1:0]    size = '0;
  logic [2:0]    mode = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          mem_req, mem_we, misalign, rvalid;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, rdata;
  logic [31:0]   mem_rdata = '0;
  logic [31:0]   mem [16];

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  endian_lsu #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .mode_i(mode), .addr_i(addr), .wdata_i(wdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .misalign_o(misalign),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[5:2]][8*i +: 8] = mem_wdata[8*i +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [2:0] m, input logic [1:0] s, input logic [AW-1:0] a,
                          input logic [31:0] d, input logic [31:0] pre,
                          input logic [3:0] exp_be, input logic [31:0] exp_mem, input string tag);
    @(negedge clk);
    mem[a[5:2]] = pre;
    req = 1; we = 1; mode = m; size = s; addr = a; wdata = d;
    #1;
    check({tag, " be"}, {28'h0, mem_be}, {28'h0, exp_be});
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
    check({tag, " mem"}, mem[a[5:2]], exp_mem);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [1:0] s, input logic [AW-1:0] a,
                         input logic [31:0] pre, input logic [2:0] later_mode,
                         input logic [31:0] exp, input string tag);
    @(negedge clk);
    mem[a[5:2]] = pre;
    req = 1; we = 0; mode = m; size = s; addr = a;
    @(posedge clk);
    @(negedge clk);
    req = 0; mode = later_mode;
    check({tag, " rvalid early"}, {31'h0, rvalid}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check({tag, " rvalid"}, {31'h0, rvalid}, 32'h1);
    check({tag, " rdata"}, rdata, exp);
    @(posedge clk);
    @(negedge clk);
    check({tag, " rvalid pulse"}, {31'h0, rvalid}, 32'h0);
  endtask

  task automatic t_reset;
    check("R8 reset rvalid", {31'h0, rvalid}, 32'h0);
    check("R8 reset rdata", rdata, 32'h0);
    check("R6 reset idle req", {31'h0, mem_req}, 32'h0);
  endtask

  task automatic t_store_word;
    do_store(3'd0, 2'd2, 32'h10, 32'h0A0B0C0D, 0, 4'hF, 32'h0A0B0C0D, "R1 word LE");
    do_store(3'd1, 2'd2, 32'h14, 32'h0A0B0C0D, 0, 4'hF, 32'h0D0C0B0A, "R2 word BE");
    do_store(3'd2, 2'd2, 32'h18, 32'h0A0B0C0D, 0, 4'hF, 32'h0A0B0C0D, "R3 word WI");
    do_store(3'd3, 2'd2, 32'h1C, 32'h0A0B0C0D, 0, 4'hF, 32'h0C0D0A0B, "R4 word mixhi");
    do_store(3'd4, 2'd2, 32'h20, 32'h0A0B0C0D, 0, 4'hF, 32'h0B0A0D0C, "R5 word mixlo");
    do_store(3'd6, 2'd2, 32'h24, 32'h81C32E47, 0, 4'hF, 32'h81C32E47, "R1 mode6 as LE");
    do_store(3'd0, 2'd3, 32'h28, 32'h81C32E47, 0, 4'hF, 32'h81C32E47, "R1 size3 as word");
  endtask

  task automatic t_store_half;
    do_store(3'd0, 2'd1, 32'h12, 32'hFFFFA1B2, 0, 4'hC, 32'hA1B20000, "R1 half LE");
    do_store(3'd1, 2'd1, 32'h12, 32'hFFFFA1B2, 0, 4'hC, 32'hB2A10000, "R2 half BE");
    do_store(3'd2, 2'd1, 32'h12, 32'hFFFFA1B2, 0, 4'h3, 32'h0000A1B2, "R3 half WI");
    do_store(3'd3, 2'd1, 32'h12, 32'hFFFFA1B2, 0, 4'hC, 32'hA1B20000, "R4 half mixhi");
    do_store(3'd4, 2'd1, 32'h12, 32'hFFFFA1B2, 0, 4'hC, 32'hB2A10000, "R5 half mixlo");
  endtask

  task automatic t_store_byte;
    do_store(3'd0, 2'd0, 32'h11, 32'hFFFFFF5E, 0, 4'h2, 32'h00005E00, "R7 byte LE");
    do_store(3'd1, 2'd0, 32'h11, 32'hFFFFFF5E, 0, 4'h2, 32'h00005E00, "R2 byte BE");
    do_store(3'd2, 2'd0, 32'h11, 32'hFFFFFF5E, 0, 4'h4, 32'h005E0000, "R3 byte WI");
    do_store(3'd2, 2'd0, 32'h13, 32'hFFFFFF81, 32'h11223344, 4'h1, 32'h11223381, "R3 byte WI off3");
    // R7: unused write lanes driven to zero
    @(negedge clk);
    req = 1; we = 1; mode = 3'd0; size = 2'd0; addr = 32'h30; wdata = 32'hDEADBEEF;
    #1;
    check("R7 unused lanes zero", mem_wdata, 32'h000000EF);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic t_load;
    do_load(3'd0, 2'd2, 32'h10, 32'h0A0B0C0D, 3'd0, 32'h0A0B0C0D, "R1 load word LE");
    do_load(3'd1, 2'd2, 32'h10, 32'h0A0B0C0D, 3'd1, 32'h0D0C0B0A, "R2 load word BE");
    do_load(3'd2, 2'd2, 32'h10, 32'h0A0B0C0D, 3'd2, 32'h0A0B0C0D, "R3 load word WI");
    do_load(3'd3, 2'd2, 32'h10, 32'h0A0B0C0D, 3'd3, 32'h0C0D0A0B, "R4 load word mixhi");
    do_load(3'd4, 2'd2, 32'h10, 32'h0A0B0C0D, 3'd4, 32'h0B0A0D0C, "R5 load word mixlo");
    do_load(3'd0, 2'd1, 32'h12, 32'h0A0B0C0D, 3'd0, 32'h00000A0B, "R8 load half LE zext");
    do_load(3'd1, 2'd1, 32'h12, 32'h0A0B0C0D, 3'd1, 32'h00000B0A, "R2 load half BE");
    do_load(3'd2, 2'd1, 32'h12, 32'h0A0B0C0D, 3'd2, 32'h00000C0D, "R3 load half WI");
    do_load(3'd4, 2'd1, 32'h12, 32'h0A0B0C0D, 3'd4, 32'h00000B0A, "R5 load half mixlo");
    do_load(3'd0, 2'd0, 32'h11, 32'h0A0B0C0D, 3'd0, 32'h0000000C, "R8 load byte LE zext");
    do_load(3'd2, 2'd0, 32'h10, 32'h0A0B0C0D, 3'd2, 32'h0000000A, "R3 load byte WI");
    do_load(3'd0, 2'd0, 32'h13, 32'hF00B0C0D, 3'd0, 32'h000000F0, "R8 load byte high zext");
  endtask

  task automatic t_mode_hold;
    do_load(3'd1, 2'd2, 32'h10, 32'h0A0B0C0D, 3'd0, 32'h0D0C0B0A, "R9 mode change after req");
    do_load(3'd2, 2'd0, 32'h10, 32'h0A0B0C0D, 3'd0, 32'h0000000A, "R9 WI byte held");
  endtask

  task automatic t_misalign(input logic [2:0] m, input logic [1:0] s, input logic [AW-1:0] a,
                            input logic w, input string tag);
    @(negedge clk);
    mem[a[5:2]] = 32'h11223344;
    req = 1; we = w; mode = m; size = s; addr = a; wdata = 32'hCAFEF00D;
    #1;
    check({tag, " flag"}, {31'h0, misalign}, 32'h1);
    check({tag, " be"}, {28'h0, mem_be}, 32'h0);
    check({tag, " req"}, {31'h0, mem_req}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " mem unchanged"}, mem[a[5:2]], 32'h11223344);
    check({tag, " no rvalid"}, {31'h0, rvalid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_store_word();
    t_store_half();
    t_store_byte();
    t_load();
    t_mode_hold();
    t_misalign(3'd0, 2'd1, 32'h41, 1'b1, "R6 half odd LE");
    t_misalign(3'd2, 2'd2, 32'h42, 1'b1, "R6 word WI");
    t_misalign(3'd4, 2'd2, 32'h43, 1'b0, "R6 word load mixlo");
    t_misalign(3'd1, 2'd3, 32'h45, 1'b1, "R6 size3 BE");
    // R8: store produces no rvalid
    do_store(3'd0, 2'd2, 32'h50, 32'h12345678, 0, 4'hF, 32'h12345678, "R8 store");
    @(negedge clk);
    check("R8 store no rvalid", {31'h0, rvalid}, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule